// File: doc/BRIEF.md
# Clock-Generator Register Bridge with Dynamic Reconfiguration Port

This block sits between a simple memory-mapped write port and the dynamic reconfiguration port of a clock primitive. Software first releases the core out of reset and turns the primitive on or off through a small run register, and it picks the input clock through a source index register. To change the primitive's internal settings it writes one command word. That write starts a single read or write transaction on the port.

A transaction has a fixed shape. The enable strobe is high for one cycle and carries the register address, the write-enable and the write data. The bridge then waits for the primitive's ready pulse. While it waits, a busy flag in the status word is set. Software polls that flag. When a read finishes, the returned 16-bit value sits in the low half of the same status word. The read port is combinational: `bus_rdata` always shows the register that `bus_addr` selects.

Top module: `drp_bridge_top`

## Requirements
- R1: After reset every register reads as zero, `drp_en` is low, busy is clear, and `core_run`, `prim_en` and `clk_sel` are zero.
- R2: A write to offset 0x40 stores bits 1:0. Bit 0 drives `core_run` and bit 1 drives `prim_en`, so 0x1 runs the core with the primitive off and 0x3 turns the primitive on. The register reads back those two bits and zero above them.
- R3: A write to offset 0x44 stores the low SEL_W bits as the clock source index. The index drives `clk_sel` and reads back zero-extended.
- R4: A write to the command register at offset 0x70 is accepted when bit 29 is set and the bridge is idle. On the next cycle `drp_en` is high for exactly one cycle, with `drp_addr` = bits 22:16, `drp_di` = bits 15:0, and `drp_we` = the inverse of bit 28 (bit 28 set means read).
- R5: A command write with bit 29 clear starts nothing. `drp_en` stays low, busy stays clear, and offset 0x70 keeps the last accepted command.
- R6: Status bit 16 at offset 0x74 rises on the cycle after an accepted command. It falls on the cycle after the clock edge that samples `drp_rdy` high while busy.
- R7: A command write while busy is ignored. No new `drp_en` pulse occurs and offset 0x70 keeps the command in flight.
- R8: When a read completes, status bits 15:0 take the value of `drp_do` that was sampled with `drp_rdy`. A completed write leaves those bits unchanged.
- R9: A `drp_rdy` pulse while idle changes neither the busy flag nor the status data.
- R10: Reads of unmapped offsets return zero. Writes to the status offset or to unmapped offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Bus request strobe |
| bus_write | input | 1 | Request is a write |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| core_run | output | 1 | Core reset released |
| prim_en | output | 1 | Clock primitive enabled |
| clk_sel | output | SEL_W | Clock source index |
| drp_en | output | 1 | Port transaction strobe, one cycle |
| drp_we | output | 1 | Port write-enable |
| drp_addr | output | 7 | Port register address |
| drp_di | output | 16 | Port write data |
| drp_do | input | 16 | Port read data |
| drp_rdy | input | 1 | Port completion pulse |

## Verification
Register writes show on `core_run`, `prim_en`, `clk_sel` and in readback one clock edge after the write is sampled. The `drp_en` strobe and busy also rise one edge after an accepted command. Busy falls one edge after `drp_rdy` is sampled, and the read data lands in status on that same edge. The bench drives every request on a falling edge. It reads the combinational read port after the next falling edge, so exactly one rising edge lies between stimulus and check. The sweep covers all 128 port addresses, alternates reads and writes, and waits from zero to three cycles for the ready pulse. Before each ready pulse it checks that the strobe has dropped and that busy holds.

// File: rtl/drp_bridge_pkg.sv
package drp_bridge_pkg;
    localparam int BUS_AW = 8;
    localparam int BUS_DW = 32;
    localparam int DRP_AW = 7;
    localparam int DRP_DW = 16;

    localparam logic [BUS_AW-1:0] OFS_RUN = 8'h40;
    localparam logic [BUS_AW-1:0] OFS_SEL = 8'h44;
    localparam logic [BUS_AW-1:0] OFS_CMD = 8'h70;
    localparam logic [BUS_AW-1:0] OFS_STS = 8'h74;

    localparam int CMD_GO_BIT   = 29;
    localparam int CMD_RD_BIT   = 28;
    localparam int CMD_ADDR_LSB = 16;
    localparam int STS_BUSY_BIT = 16;

    typedef struct packed {
        logic              busy;
        logic              en;
        logic              we;
        logic [DRP_AW-1:0] addr;
        logic [DRP_DW-1:0] di;
        logic [DRP_DW-1:0] rdata;
        logic [BUS_DW-1:0] cmd;
    } seq_state_t;
endpackage

// File: rtl/drp_bridge_seq.sv
module drp_bridge_seq
    import drp_bridge_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [BUS_DW-1:0] cmd_word,
    input  logic [DRP_DW-1:0] drp_do,
    input  logic              drp_rdy,
    output logic              drp_en,
    output logic              drp_we,
    output logic [DRP_AW-1:0] drp_addr,
    output logic [DRP_DW-1:0] drp_di,
    output logic              seq_busy,
    output logic [DRP_DW-1:0] seq_rdata,
    output logic [BUS_DW-1:0] seq_cmd
);
    seq_state_t st_d, st_q;
    logic       launch;

    always_comb begin
        st_d    = st_q;
        st_d.en = 1'b0;
        launch  = cmd_wr && cmd_word[CMD_GO_BIT] && !st_q.busy;
        if (launch) begin
            st_d.busy = 1'b1;
            st_d.en   = 1'b1;
            st_d.we   = !cmd_word[CMD_RD_BIT];
            st_d.addr = cmd_word[CMD_ADDR_LSB +: DRP_AW];
            st_d.di   = cmd_word[DRP_DW-1:0];
            st_d.cmd  = cmd_word;
        end
        if (st_q.busy && drp_rdy) begin
            st_d.busy = 1'b0;
            if (!st_q.we) st_d.rdata = drp_do;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign drp_en    = st_q.en;
    assign drp_we    = st_q.we;
    assign drp_addr  = st_q.addr;
    assign drp_di    = st_q.di;
    assign seq_busy  = st_q.busy;
    assign seq_rdata = st_q.rdata;
    assign seq_cmd   = st_q.cmd;

    // R4
    launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_word[CMD_GO_BIT] && !seq_busy) |=> (drp_en && seq_busy));
    // R4
    en_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drp_en |=> !drp_en);
    // R6
    done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_busy && drp_rdy) |=> !seq_busy);
    // R7
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_busy && !drp_rdy) |=> (seq_busy && !drp_en && $stable(seq_cmd)));
    // R8
    rd_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_busy && drp_rdy && !drp_we) |=> (seq_rdata == $past(drp_do)));
    // R9
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!seq_busy && !(cmd_wr && cmd_word[CMD_GO_BIT])) |=> (!seq_busy && $stable(seq_rdata)));
endmodule

// File: rtl/drp_bridge_regs.sv
module drp_bridge_regs
    import drp_bridge_pkg::*;
#(
    parameter int SEL_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [1:0]        run_bits,
    input  logic [SEL_W-1:0]  sel_bits,
    output logic [BUS_DW-1:0] bus_rdata,
    output logic              cmd_wr,
    input  logic              seq_busy,
    input  logic [DRP_DW-1:0] seq_rdata,
    input  logic [BUS_DW-1:0] seq_cmd,
    output logic              core_run,
    output logic              prim_en,
    output logic [SEL_W-1:0]  clk_sel
);
    localparam int STS_PAD = BUS_DW - DRP_DW - 1;

    typedef struct packed {
        logic [1:0]       run;
        logic [SEL_W-1:0] sel;
    } reg_state_t;

    reg_state_t rg_d, rg_q;
    logic       wr_hit;

    always_comb begin
        rg_d   = rg_q;
        wr_hit = bus_valid && bus_write;
        cmd_wr = wr_hit && (bus_addr == OFS_CMD);
        if (wr_hit && bus_addr == OFS_RUN) rg_d.run = run_bits;
        if (wr_hit && bus_addr == OFS_SEL) rg_d.sel = sel_bits;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    always_comb begin
        case (bus_addr)
            OFS_RUN: bus_rdata = BUS_DW'(rg_q.run);
            OFS_SEL: bus_rdata = BUS_DW'(rg_q.sel);
            OFS_CMD: bus_rdata = seq_cmd;
            OFS_STS: bus_rdata = {{STS_PAD{1'b0}}, seq_busy, seq_rdata};
            default: bus_rdata = '0;
        endcase
    end

    assign core_run = rg_q.run[0];
    assign prim_en  = rg_q.run[1];
    assign clk_sel  = rg_q.sel;

    // R2
    run_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_addr == OFS_RUN) |=> ({prim_en, core_run} == $past(run_bits)));
    // R3
    sel_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_addr == OFS_SEL) |=> (clk_sel == $past(sel_bits)));
    // R10
    sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && bus_write && bus_addr == OFS_SEL) |=> $stable(clk_sel));
endmodule

// File: rtl/drp_bridge_top.sv
module drp_bridge_top
    import drp_bridge_pkg::*;
#(
    parameter int SEL_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [BUS_DW-1:0] bus_wdata,
    output logic [BUS_DW-1:0] bus_rdata,
    output logic              core_run,
    output logic              prim_en,
    output logic [SEL_W-1:0]  clk_sel,
    output logic              drp_en,
    output logic              drp_we,
    output logic [DRP_AW-1:0] drp_addr,
    output logic [DRP_DW-1:0] drp_di,
    input  logic [DRP_DW-1:0] drp_do,
    input  logic              drp_rdy
);
    logic              cmd_wr;
    logic              seq_busy;
    logic [DRP_DW-1:0] seq_rdata;
    logic [BUS_DW-1:0] seq_cmd;

    drp_bridge_regs #(.SEL_W(SEL_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .run_bits  (bus_wdata[1:0]),
        .sel_bits  (bus_wdata[SEL_W-1:0]),
        .bus_rdata (bus_rdata),
        .cmd_wr    (cmd_wr),
        .seq_busy  (seq_busy),
        .seq_rdata (seq_rdata),
        .seq_cmd   (seq_cmd),
        .core_run  (core_run),
        .prim_en   (prim_en),
        .clk_sel   (clk_sel)
    );

    drp_bridge_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_wr    (cmd_wr),
        .cmd_word  (bus_wdata),
        .drp_do    (drp_do),
        .drp_rdy   (drp_rdy),
        .drp_en    (drp_en),
        .drp_we    (drp_we),
        .drp_addr  (drp_addr),
        .drp_di    (drp_di),
        .seq_busy  (seq_busy),
        .seq_rdata (seq_rdata),
        .seq_cmd   (seq_cmd)
    );
endmodule

// File: tb/sim_drp_bridge_top.sv
`timescale 1ns/1ps
module sim_drp_bridge_top;
    localparam int SEL_W = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        core_run, prim_en;
    logic [SEL_W-1:0] clk_sel;
    logic        drp_en, drp_we;
    logic [6:0]  drp_addr;
    logic [15:0] drp_di;
    logic [15:0] drp_do = '0;
    logic        drp_rdy = 1'b0;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    drp_bridge_top #(.SEL_W(SEL_W)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .core_run(core_run), .prim_en(prim_en), .clk_sel(clk_sel),
        .drp_en(drp_en), .drp_we(drp_we), .drp_addr(drp_addr), .drp_di(drp_di),
        .drp_do(drp_do), .drp_rdy(drp_rdy)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0; bus_wdata = '0;
    endtask

    task automatic peek(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic respond(input logic [15:0] v);
        drp_rdy = 1'b1; drp_do = v;
        @(negedge clk);
        drp_rdy = 1'b0; drp_do = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        logic [31:0] last_cmd;
        logic [15:0] last_rdata;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        peek(8'h40, rd); chk("R1 run reg", rd, 0);
        peek(8'h44, rd); chk("R1 sel reg", rd, 0);
        peek(8'h70, rd); chk("R1 cmd reg", rd, 0);
        peek(8'h74, rd); chk("R1 status", rd, 0);
        chk("R1 outputs", {drp_en, core_run, prim_en, 30'(clk_sel)}, 0);

        // R2 run register sweep, upper bits junk
        for (int v = 0; v < 8; v++) begin
            bus_wr(8'h40, 32'hABCDEF00 | 32'(v));
            peek(8'h40, rd); chk("R2 readback", rd, 32'(v & 3));
            chk("R2 core_run", {31'b0, core_run}, 32'(v & 1));
            chk("R2 prim_en", {31'b0, prim_en}, 32'((v >> 1) & 1));
        end
        bus_wr(8'h40, 32'h1);
        chk("R2 0x1 primitive off", {30'b0, prim_en, core_run}, 32'h1);
        bus_wr(8'h40, 32'h3);
        chk("R2 0x3 primitive on", {30'b0, prim_en, core_run}, 32'h3);

        // R3 source index sweep
        for (int v = 0; v < 16; v++) begin
            bus_wr(8'h44, 32'h5500 | 32'(v));
            peek(8'h44, rd); chk("R3 readback", rd, 32'(v & ((1 << SEL_W) - 1)));
            chk("R3 clk_sel", 32'(clk_sel), 32'(v & ((1 << SEL_W) - 1)));
        end

        // R5 command without the go bit
        bus_wr(8'h70, 32'h1012_3456);
        chk("R5 no strobe", {31'b0, drp_en}, 0);
        peek(8'h74, rd); chk("R5 busy clear", rd, 0);
        peek(8'h70, rd); chk("R5 cmd unchanged", rd, 0);

        // R9 ready while idle
        respond(16'hBEEF);
        peek(8'h74, rd); chk("R9 status unchanged", rd, 0);

        // R4 R6 R7 R8 sweep over all port addresses
        last_rdata = '0;
        for (int a = 0; a < 128; a++) begin
            automatic logic        is_rd = a[0];
            automatic logic [15:0] wd = 16'(a * 16'h0137) ^ 16'hA5C3;
            automatic logic [15:0] resp = ~wd;
            automatic int          lat = a % 4;
            automatic logic [31:0] word = (32'h1 << 29) | (32'(is_rd) << 28) | (32'(a) << 16) | 32'(wd);
            bus_wr(8'h70, word);
            last_cmd = word;
            chk("R4 strobe", {31'b0, drp_en}, 1);
            chk("R4 addr", 32'(drp_addr), 32'(a));
            chk("R4 we", {31'b0, drp_we}, {31'b0, !is_rd});
            chk("R4 data", 32'(drp_di), 32'(wd));
            peek(8'h74, rd); chk("R6 busy rise", rd, 32'h10000 | 32'(last_rdata));
            for (int i = 0; i < lat; i++) begin
                if (i == 0 && (a % 8) == 3)
                    bus_wr(8'h70, 32'h3055_0000 | 32'(a)); // R7 ignored while busy
                else
                    @(negedge clk);
                chk("R4 single strobe", {31'b0, drp_en}, 0);
                peek(8'h74, rd); chk("R6 busy held", rd[16] ? 32'h1 : 32'h0, 32'h1);
                peek(8'h70, rd); chk("R7 cmd kept", rd, last_cmd);
            end
            respond(resp);
            if (is_rd) last_rdata = resp;
            peek(8'h74, rd); chk("R8 status after done", rd, 32'(last_rdata));
            chk("R7 no extra strobe", {31'b0, drp_en}, 0);
        end

        // R10 unmapped reads and ignored writes
        peek(8'h00, rd); chk("R10 unmapped 00", rd, 0);
        peek(8'h48, rd); chk("R10 unmapped 48", rd, 0);
        peek(8'hFC, rd); chk("R10 unmapped FC", rd, 0);
        bus_wr(8'h74, 32'hFFFF_FFFF);
        peek(8'h74, rd); chk("R10 status write ignored", rd, 32'(last_rdata));
        bus_wr(8'h50, 32'hFFFF_FFFF);
        peek(8'h40, rd); chk("R10 run untouched", rd, 32'h3);
        peek(8'h44, rd); chk("R10 sel untouched", rd, 32'(15 & ((1 << SEL_W) - 1)));
        peek(8'h70, rd); chk("R10 cmd untouched", rd, last_cmd);
        chk("R10 no strobe", {31'b0, drp_en}, 0);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule